// File: doc/BRIEF.md
# Host ROM Gate with Vector Override

This block arbitrates host access to a program ROM that is shared with a coprocessor. A host read of the ROM region goes to the ROM only while the coprocessor is halted. In that case the address is folded onto the ROM size, so every alias of a location returns the same byte. While the coprocessor runs, the ROM is locked out. A host read that falls in the interrupt-vector window is then served from a 32-byte override table. Every other ROM read returns the last byte that crossed the host data bus, which models an open bus.

The same block serves the cartridge RAM port, folding addresses onto the RAM size. A RAM size of zero is legal. In that case reads return zero instead of open-bus data, and writes are discarded. A separate combinational gate confines the coprocessor's own reach onto the host bus to two address windows. All reads of the ROM and RAM arrays are synchronous, so a host read is answered one cycle after its request.

Top module: `host_rom_gate`

## Requirements
- R1: While `cop_running` is 0, a host ROM read of address A returns ROM byte `A & (ROM_SIZE-1)` in the cycle after the request, with `host_rvalid` high. This includes addresses inside the vector window.
- R2: While `cop_running` is 1, a host ROM read whose address satisfies `(A & 0x40FFE0) == 0x00FFE0` returns override table entry `A[4:0]`.
- R3: While `cop_running` is 1, any other host ROM read returns the current open-bus byte.
- R4: The open-bus byte is 0x00 after reset. It takes the value returned by every answered read and the data of every host write.
- R5: Host writes to the ROM region never strobe the ROM. A later halted read of the same location returns the original contents.
- R6: Host RAM reads and writes use address `A & (RAM_SIZE-1)`, whatever the run state. A read is answered one cycle later.
- R7: With `RAM_SIZE` = 0, RAM reads return 0x00 and RAM writes never raise `ram_we`.
- R8: A coprocessor access reaches the host bus only in banks 00-3F/80-BF at offsets 6000-7FFF, or in banks 70-77 at offsets 0000-7FFF. Any other coprocessor read returns 0x00 and raises no `cop_bus_req`.
- R9: A write on the table port with `vec_we` stores `vec_wdata` in entry `vec_idx`, and the next read of that entry returns it.
- R10: `host_rvalid` is high exactly in the cycle after a read with `host_rom_sel` or `host_ram_sel` set. It is low after a write.
- R11: `rom_re` is never high while `cop_running` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cop_running | input | 1 | Coprocessor run state (1 = running) |
| host_req | input | 1 | Host bus cycle request |
| host_we | input | 1 | Host cycle is a write |
| host_rom_sel | input | 1 | Host cycle targets the ROM region |
| host_ram_sel | input | 1 | Host cycle targets the RAM region |
| host_addr | input | 24 | Host address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read response strobe |
| vec_we | input | 1 | Override table write strobe |
| vec_idx | input | 5 | Override table entry |
| vec_wdata | input | 8 | Override table write data |
| rom_re | output | 1 | ROM read strobe |
| rom_addr | output | ROM_AW | Folded ROM address |
| rom_rdata | input | 8 | ROM data, one cycle after rom_re |
| ram_re | output | 1 | RAM read strobe |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | RAM_AW | Folded RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM data, one cycle after ram_re |
| cop_req | input | 1 | Coprocessor bus request |
| cop_we | input | 1 | Coprocessor request is a write |
| cop_addr | input | 24 | Coprocessor address |
| cop_wdata | input | 8 | Coprocessor write data |
| cop_rdata | output | 8 | Data returned to the coprocessor |
| cop_bus_req | output | 1 | Coprocessor request forwarded to host bus |
| cop_bus_we | output | 1 | Forwarded request is a write |
| cop_bus_addr | output | 24 | Forwarded address |
| cop_bus_wdata | output | 8 | Forwarded write data |
| cop_bus_rdata | input | 8 | Host bus data for the coprocessor |

## Verification
The assertions rely on a few properties of the inputs. The ROM and RAM models answer one cycle after their strobes. `host_rom_sel` and `host_ram_sel` are never both high. `cop_running` and the override table do not change between a read request and its response. The stimulus follows these rules by construction. Each host access is a single request cycle followed by an idle cycle. The run state and the table are changed only between accesses, and the two select lines are driven from exclusive task arguments.

// File: rtl/hrg_pkg.sv
package hrg_pkg;
    localparam int HRG_DW   = 8;
    localparam int HRG_AW   = 24;
    localparam int VEC_NUM  = 32;
    localparam int VEC_IW   = $clog2(VEC_NUM);

    // Host-side interrupt-vector window
    localparam logic [HRG_AW-1:0] VEC_WIN_MASK  = 24'h40FFE0;
    localparam logic [HRG_AW-1:0] VEC_WIN_MATCH = 24'h00FFE0;

    // Coprocessor reach onto the host bus
    localparam logic [HRG_AW-1:0] COP_LO_MASK  = 24'h40E000;
    localparam logic [HRG_AW-1:0] COP_LO_MATCH = 24'h006000;
    localparam logic [HRG_AW-1:0] COP_HI_MASK  = 24'hF88000;
    localparam logic [HRG_AW-1:0] COP_HI_MATCH = 24'h700000;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_ROM,
        SRC_RAM,
        SRC_VEC,
        SRC_OPEN,
        SRC_ZERO
    } hrg_src_e;

    typedef struct packed {
        hrg_src_e          src;
        logic [HRG_DW-1:0] vec;
        logic [HRG_DW-1:0] bus;
    } hrg_state_t;
endpackage

// File: rtl/hrg_vec_table.sv
module hrg_vec_table #(
    parameter int ENTRIES = 32,
    parameter int DW      = 8,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] ent_flat [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        logic [DW-1:0] ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (wr_en && (wr_idx == IW'(e))) begin
                ent_d = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign ent_flat[e] = ent_q;
    end

    assign rd_data = ent_flat[rd_idx];
endmodule

// File: rtl/hrg_host_decode.sv
module hrg_host_decode
    import hrg_pkg::*;
#(
    parameter int ROM_AW      = 12,
    parameter int RAM_AW      = 11,
    parameter bit RAM_PRESENT = 1'b1
) (
    input  logic              req,
    input  logic              we,
    input  logic              rom_sel,
    input  logic              ram_sel,
    input  logic              running,
    input  logic [HRG_AW-1:0] addr,
    output hrg_src_e          src,
    output logic              rom_re,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              ram_re,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr
);
    logic rd_cyc, wr_cyc, vec_hit;

    assign rd_cyc  = req && !we;
    assign wr_cyc  = req && we;
    assign vec_hit = ((addr & VEC_WIN_MASK) == VEC_WIN_MATCH);

    // ROM takes priority over RAM if both selects are set.
    always_comb begin
        src    = SRC_NONE;
        rom_re = 1'b0;
        if (rd_cyc && rom_sel) begin
            if (!running) begin
                src    = SRC_ROM;
                rom_re = 1'b1;
            end else if (vec_hit) begin
                src = SRC_VEC;
            end else begin
                src = SRC_OPEN;
            end
        end else if (rd_cyc && ram_sel) begin
            src = RAM_PRESENT ? SRC_RAM : SRC_ZERO;
        end
    end

    assign rom_addr = addr[ROM_AW-1:0];

    if (RAM_PRESENT) begin : g_ram
        assign ram_re   = rd_cyc && ram_sel && !rom_sel;
        assign ram_we   = wr_cyc && ram_sel && !rom_sel;
        assign ram_addr = addr[RAM_AW-1:0];
    end else begin : g_no_ram
        assign ram_re   = 1'b0;
        assign ram_we   = 1'b0;
        assign ram_addr = '0;
    end
endmodule

// File: rtl/hrg_cop_window.sv
module hrg_cop_window
    import hrg_pkg::*;
(
    input  logic              cop_req,
    input  logic              cop_we,
    input  logic [HRG_AW-1:0] cop_addr,
    input  logic [HRG_DW-1:0] cop_wdata,
    output logic [HRG_DW-1:0] cop_rdata,
    output logic              cop_bus_req,
    output logic              cop_bus_we,
    output logic [HRG_AW-1:0] cop_bus_addr,
    output logic [HRG_DW-1:0] cop_bus_wdata,
    input  logic [HRG_DW-1:0] cop_bus_rdata
);
    logic in_lo, in_hi, in_win;

    assign in_lo  = ((cop_addr & COP_LO_MASK) == COP_LO_MATCH);
    assign in_hi  = ((cop_addr & COP_HI_MASK) == COP_HI_MATCH);
    assign in_win = in_lo || in_hi;

    assign cop_bus_req   = cop_req && in_win;
    assign cop_bus_we    = cop_req && cop_we && in_win;
    assign cop_bus_addr  = cop_addr;
    assign cop_bus_wdata = cop_wdata;
    assign cop_rdata     = (cop_req && !cop_we && in_win) ? cop_bus_rdata : '0;
endmodule

// File: rtl/host_rom_gate.sv
module host_rom_gate
    import hrg_pkg::*;
#(
    parameter int  ROM_SIZE    = 4096,
    parameter int  RAM_SIZE    = 2048,
    localparam int ROM_AW      = (ROM_SIZE > 1) ? $clog2(ROM_SIZE) : 1,
    localparam int RAM_AW      = (RAM_SIZE > 1) ? $clog2(RAM_SIZE) : 1,
    localparam bit RAM_PRESENT = (RAM_SIZE > 0)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cop_running,
    input  logic              host_req,
    input  logic              host_we,
    input  logic              host_rom_sel,
    input  logic              host_ram_sel,
    input  logic [23:0]       host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              host_rvalid,
    input  logic              vec_we,
    input  logic [4:0]        vec_idx,
    input  logic [7:0]        vec_wdata,
    output logic              rom_re,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [7:0]        rom_rdata,
    output logic              ram_re,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata,
    input  logic              cop_req,
    input  logic              cop_we,
    input  logic [23:0]       cop_addr,
    input  logic [7:0]        cop_wdata,
    output logic [7:0]        cop_rdata,
    output logic              cop_bus_req,
    output logic              cop_bus_we,
    output logic [23:0]       cop_bus_addr,
    output logic [7:0]        cop_bus_wdata,
    input  logic [7:0]        cop_bus_rdata
);
    hrg_state_t        st_d, st_q;
    hrg_src_e          dec_src;
    logic [HRG_DW-1:0] vec_rd;

    hrg_host_decode #(
        .ROM_AW      (ROM_AW),
        .RAM_AW      (RAM_AW),
        .RAM_PRESENT (RAM_PRESENT)
    ) u_decode (
        .req      (host_req),
        .we       (host_we),
        .rom_sel  (host_rom_sel),
        .ram_sel  (host_ram_sel),
        .running  (cop_running),
        .addr     (host_addr),
        .src      (dec_src),
        .rom_re   (rom_re),
        .rom_addr (rom_addr),
        .ram_re   (ram_re),
        .ram_we   (ram_we),
        .ram_addr (ram_addr)
    );

    hrg_vec_table #(
        .ENTRIES (VEC_NUM),
        .DW      (HRG_DW)
    ) u_vec (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (vec_we),
        .wr_idx  (vec_idx),
        .wr_data (vec_wdata),
        .rd_idx  (host_addr[VEC_IW-1:0]),
        .rd_data (vec_rd)
    );

    hrg_cop_window u_cop (
        .cop_req       (cop_req),
        .cop_we        (cop_we),
        .cop_addr      (cop_addr),
        .cop_wdata     (cop_wdata),
        .cop_rdata     (cop_rdata),
        .cop_bus_req   (cop_bus_req),
        .cop_bus_we    (cop_bus_we),
        .cop_bus_addr  (cop_bus_addr),
        .cop_bus_wdata (cop_bus_wdata),
        .cop_bus_rdata (cop_bus_rdata)
    );

    assign ram_wdata   = host_wdata;
    assign host_rvalid = (st_q.src != SRC_NONE);

    // Response mux: memory data arrives in the cycle after its strobe.
    always_comb begin
        case (st_q.src)
            SRC_ROM:  host_rdata = rom_rdata;
            SRC_RAM:  host_rdata = ram_rdata;
            SRC_VEC:  host_rdata = st_q.vec;
            SRC_OPEN: host_rdata = st_q.bus;
            default:  host_rdata = '0;
        endcase
    end

    always_comb begin
        st_d     = st_q;
        st_d.src = dec_src;
        if (dec_src == SRC_VEC) begin
            st_d.vec = vec_rd;
        end
        if (host_rvalid) begin
            st_d.bus = host_rdata;
        end
        if (host_req && host_we) begin
            st_d.bus = host_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{src: SRC_NONE, vec: '0, bus: '0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/host_rom_gate_chk.sv
module host_rom_gate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cop_running,
    input logic       host_req,
    input logic       host_we,
    input logic       host_rom_sel,
    input logic       host_ram_sel,
    input logic [7:0] host_rdata,
    input logic       host_rvalid,
    input logic       rom_re,
    input logic [7:0] rom_rdata,
    input logic [7:0] cop_rdata,
    input logic       cop_bus_req
);
    logic sel_read;
    assign sel_read = host_req && !host_we && (host_rom_sel || host_ram_sel);

    // R10
    a_r10_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
        sel_read |=> host_rvalid);

    // R10
    a_r10_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_read |=> !host_rvalid);

    // R11
    a_r11_rom_locked: assert property (@(posedge clk) disable iff (!rst_n)
        cop_running |-> !rom_re);

    // R5
    a_r5_write_no_rom: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_we) |-> !rom_re);

    // R1
    a_r1_rom_data: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rvalid && $past(rom_re)) |-> (host_rdata == rom_rdata));

    // R8
    a_r8_cop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cop_bus_req |-> (cop_rdata == 8'h00));
endmodule

bind host_rom_gate host_rom_gate_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cop_running  (cop_running),
    .host_req     (host_req),
    .host_we      (host_we),
    .host_rom_sel (host_rom_sel),
    .host_ram_sel (host_ram_sel),
    .host_rdata   (host_rdata),
    .host_rvalid  (host_rvalid),
    .rom_re       (rom_re),
    .rom_rdata    (rom_rdata),
    .cop_rdata    (cop_rdata),
    .cop_bus_req  (cop_bus_req)
);

// File: tb/sim_host_rom_gate.sv
module sim_host_rom_gate;
    localparam int ROM_SZ = 1024;
    localparam int RAM_SZ = 256;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        cop_running = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0, host_rom_sel = 1'b0, host_ram_sel = 1'b0;
    logic [23:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        vec_we = 1'b0;
    logic [4:0]  vec_idx = '0;
    logic [7:0]  vec_wdata = '0;
    logic        cop_req = 1'b0, cop_we = 1'b0;
    logic [23:0] cop_addr = '0;
    logic [7:0]  cop_wdata = '0;
    logic [7:0]  cop_bus_rdata = 8'h77;

    // instance u0: sized RAM
    logic [7:0] rdata0, rom_q0, ram_q0, cop_rdata0, cop_bus_wdata0;
    logic       rvalid0, rom_re0, ram_re0, ram_we0, cop_bus_req0, cop_bus_we0;
    logic [9:0] rom_addr0;
    logic [7:0] ram_addr0, ram_wdata0;
    logic [23:0] cop_bus_addr0;

    // instance u1: zero-size RAM
    logic [7:0] rdata1, rom_q1, cop_rdata1, cop_bus_wdata1, ram_wdata1;
    logic       rvalid1, rom_re1, ram_re1, ram_we1, cop_bus_req1, cop_bus_we1;
    logic [9:0] rom_addr1;
    logic [0:0] ram_addr1;
    logic [23:0] cop_bus_addr1;

    host_rom_gate #(.ROM_SIZE(ROM_SZ), .RAM_SIZE(RAM_SZ)) u0 (
        .clk(clk), .rst_n(rst_n), .cop_running(cop_running),
        .host_req(host_req), .host_we(host_we), .host_rom_sel(host_rom_sel),
        .host_ram_sel(host_ram_sel), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(rdata0), .host_rvalid(rvalid0),
        .vec_we(vec_we), .vec_idx(vec_idx), .vec_wdata(vec_wdata),
        .rom_re(rom_re0), .rom_addr(rom_addr0), .rom_rdata(rom_q0),
        .ram_re(ram_re0), .ram_we(ram_we0), .ram_addr(ram_addr0),
        .ram_wdata(ram_wdata0), .ram_rdata(ram_q0),
        .cop_req(cop_req), .cop_we(cop_we), .cop_addr(cop_addr), .cop_wdata(cop_wdata),
        .cop_rdata(cop_rdata0), .cop_bus_req(cop_bus_req0), .cop_bus_we(cop_bus_we0),
        .cop_bus_addr(cop_bus_addr0), .cop_bus_wdata(cop_bus_wdata0),
        .cop_bus_rdata(cop_bus_rdata)
    );

    host_rom_gate #(.ROM_SIZE(ROM_SZ), .RAM_SIZE(0)) u1 (
        .clk(clk), .rst_n(rst_n), .cop_running(cop_running),
        .host_req(host_req), .host_we(host_we), .host_rom_sel(host_rom_sel),
        .host_ram_sel(host_ram_sel), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(rdata1), .host_rvalid(rvalid1),
        .vec_we(vec_we), .vec_idx(vec_idx), .vec_wdata(vec_wdata),
        .rom_re(rom_re1), .rom_addr(rom_addr1), .rom_rdata(rom_q1),
        .ram_re(ram_re1), .ram_we(ram_we1), .ram_addr(ram_addr1),
        .ram_wdata(ram_wdata1), .ram_rdata(8'hAA),
        .cop_req(1'b0), .cop_we(1'b0), .cop_addr(24'h0), .cop_wdata(8'h0),
        .cop_rdata(cop_rdata1), .cop_bus_req(cop_bus_req1), .cop_bus_we(cop_bus_we1),
        .cop_bus_addr(cop_bus_addr1), .cop_bus_wdata(cop_bus_wdata1),
        .cop_bus_rdata(8'h55)
    );

    function automatic logic [7:0] rom_f(input int a);
        return 8'((a * 37 + 11) ^ (a >> 3));
    endfunction

    function automatic logic [7:0] vec_f(input int i);
        return 8'(8'hC0 ^ (i * 5));
    endfunction

    // Memory models
    logic [7:0] ram_mem [RAM_SZ];
    always_ff @(posedge clk) begin
        if (rom_re0) rom_q0 <= rom_f(int'(rom_addr0));
        if (rom_re1) rom_q1 <= rom_f(int'(rom_addr1));
        if (ram_we0) ram_mem[ram_addr0] <= ram_wdata0;
        if (ram_re0) ram_q0 <= ram_mem[ram_addr0];
    end

    // Port monitors
    int lock_viol = 0, wr_strobe = 0, zero_ram_we = 0;
    always @(posedge clk) begin
        if (rst_n && cop_running && (rom_re0 || rom_re1)) lock_viol++;
        if (rst_n && host_req && host_we && (rom_re0 || rom_re1)) wr_strobe++;
        if (rst_n && ram_we1) zero_ram_we++;
    end

    int n_cmp = 0, n_bad = 0;
    bit finished = 1'b0;
    logic [7:0] exp_bus = 8'h00;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic host_read(input logic rs, input logic [23:0] a,
                             output logic [7:0] d0, output logic [7:0] d1,
                             output logic v0, output logic v1);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_rom_sel = rs; host_ram_sel = !rs;
        host_addr = a;
        @(negedge clk);
        host_req = 1'b0; host_rom_sel = 1'b0; host_ram_sel = 1'b0;
        d0 = rdata0; d1 = rdata1; v0 = rvalid0; v1 = rvalid1;
    endtask

    task automatic host_write(input logic rs, input logic [23:0] a, input logic [7:0] d);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_rom_sel = rs; host_ram_sel = !rs;
        host_addr = a; host_wdata = d;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0; host_rom_sel = 1'b0; host_ram_sel = 1'b0;
        chk("R10 no response after write", {7'd0, rvalid0}, 8'd0);
        exp_bus = d;
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog R10 actual=timeout expected=completion");
            report();
            $finish;
        end
    end

    initial begin
        logic [7:0] d0, d1;
        logic v0, v1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R4 reset rvalid", {7'd0, rvalid0}, 8'd0);
        chk("R4 reset rdata", rdata0, 8'h00);

        // open bus after reset
        cop_running = 1'b1;
        host_read(1'b1, 24'h123456, d0, d1, v0, v1);
        chk("R4 open bus reset value", d0, 8'h00);
        chk("R10 rvalid on read", {7'd0, v0}, 8'd1);

        // load override table
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            vec_we = 1'b1; vec_idx = 5'(i); vec_wdata = vec_f(i);
        end
        @(negedge clk);
        vec_we = 1'b0;

        // vector window reads while running
        for (int b = 0; b < 4; b++) begin
            logic [7:0] bank;
            bank = (b == 0) ? 8'h00 : (b == 1) ? 8'h3F : (b == 2) ? 8'h80 : 8'hBF;
            for (int i = 0; i < 32; i++) begin
                host_read(1'b1, {bank, 16'hFFE0 + 16'(i)}, d0, d1, v0, v1);
                chk("R2 vector override", d0, vec_f(i));
                exp_bus = vec_f(i);
            end
        end

        // R3 open bus follows last vector byte
        host_read(1'b1, 24'h40FFE3, d0, d1, v0, v1);
        chk("R3 open bus after vector read", d0, exp_bus);

        // R4/R5 write captured as open bus, no ROM strobe
        host_write(1'b1, 24'h008000, 8'h3C);
        host_read(1'b1, 24'h00FFDF, d0, d1, v0, v1);
        chk("R3 R4 open bus holds write data", d0, 8'h3C);
        host_read(1'b1, 24'h00FFC5, d0, d1, v0, v1);
        chk("R3 open bus below window", d0, 8'h3C);
        host_read(1'b1, 24'hC0FFFF, d0, d1, v0, v1);
        chk("R3 open bus bank C0", d0, 8'h3C);
        host_write(1'b1, 24'h808000, 8'hA5);
        host_read(1'b1, 24'h40FFE0, d0, d1, v0, v1);
        chk("R3 open bus second write", d0, 8'hA5);

        // R9 overwrite one entry
        @(negedge clk);
        vec_we = 1'b1; vec_idx = 5'd7; vec_wdata = 8'h19;
        @(negedge clk);
        vec_we = 1'b0;
        host_read(1'b1, 24'h00FFE7, d0, d1, v0, v1);
        chk("R9 table entry rewrite", d0, 8'h19);

        // halted: full ROM sweep with aliased upper address bits
        @(negedge clk);
        cop_running = 1'b0;
        for (int a = 0; a < ROM_SZ; a++) begin
            logic [23:0] addr;
            addr = 24'(a) | 24'(((a * 13) & 63) << 10) | 24'((a & 255) << 16);
            host_read(1'b1, addr, d0, d1, v0, v1);
            chk("R1 halted ROM read", d0, rom_f(a));
        end
        host_read(1'b1, 24'h00FFE5, d0, d1, v0, v1);
        chk("R1 halted read in vector window", d0, rom_f(32'h3E5));

        // R5 ROM write ignored while halted
        host_write(1'b1, 24'h000155, 8'h99);
        host_read(1'b1, 24'h000155, d0, d1, v0, v1);
        chk("R5 ROM unchanged after write", d0, rom_f(32'h155));

        // RAM: write through one alias, read through another
        for (int i = 0; i < RAM_SZ; i++) begin
            host_write(1'b0, 24'h700000 + 24'(i) + 24'((i % 5) << 8), 8'(i * 3 + 1));
        end
        for (int i = 0; i < RAM_SZ; i++) begin
            if (i == 100) cop_running = 1'b1;
            host_read(1'b0, 24'h012300 + 24'(i), d0, d1, v0, v1);
            chk("R6 RAM mirrored read", d0, 8'(i * 3 + 1));
            chk("R7 zero-size RAM read", d1, 8'h00);
            chk("R10 RAM read rvalid", {7'd0, v1}, 8'd1);
        end
        cop_running = 1'b0;
        chk("R7 zero-size RAM write strobes", 8'(zero_ram_we), 8'd0);

        // coprocessor window sweep
        for (int b = 0; b < 256; b++) begin
            for (int k = 0; k < 6; k++) begin
                int off;
                bit lo, hi, inw;
                off = (k == 0) ? 16'h0000 : (k == 1) ? 16'h5FFF : (k == 2) ? 16'h6000 :
                      (k == 3) ? 16'h7FFF : (k == 4) ? 16'h8000 : 16'hFFFF;
                lo  = ((b <= 8'h3F) || (b >= 8'h80 && b <= 8'hBF)) &&
                      (off >= 16'h6000 && off <= 16'h7FFF);
                hi  = (b >= 8'h70 && b <= 8'h77) && (off <= 16'h7FFF);
                inw = lo || hi;
                @(negedge clk);
                cop_req = 1'b1; cop_we = 1'b0; cop_addr = {8'(b), 16'(off)};
                #1;
                chk("R8 cop window request", {7'd0, cop_bus_req0}, {7'd0, inw});
                chk("R8 cop window read data", cop_rdata0, inw ? 8'h77 : 8'h00);
            end
        end
        @(negedge clk);
        cop_we = 1'b1; cop_addr = 24'h756000;
        #1;
        chk("R8 cop write inside window", {7'd0, cop_bus_we0}, 8'd1);
        cop_addr = 24'h40FFFF;
        #1;
        chk("R8 cop write outside window", {7'd0, cop_bus_we0}, 8'd0);
        @(negedge clk);
        cop_req = 1'b0; cop_we = 1'b0;

        chk("R11 ROM strobe while running", 8'(lock_viol), 8'd0);
        chk("R5 ROM strobe during write", 8'(wr_strobe), 8'd0);

        finished = 1'b1;
        report();
        $finish;
    end
endmodule